// File: doc/BRIEF.md
# FPU environment store sequencer

This block writes the floating-point unit's saved environment to memory when a store-environment instruction issues. The saved environment covers the control, status and tag words, the instruction and data pointers, and the last opcode. A one-cycle `start` pulse captures every environment input into a snapshot. The block then checks the instruction for faults. If no fault applies, it writes the image as seven items over a sequential valid/ready write port, in ascending address order.

The image has two sizes. With a 32-bit operand size it is seven 4-byte slots (28 bytes). With a 16-bit operand size it is seven 2-byte items (14 bytes).

The pointer layout depends on the mode:
- In protected mode the pointers are stored as offset and selector.
- In real mode, and in virtual-8086 mode, the pointers are stored as 20-bit linear addresses (selector shifted left by 4, plus the low 16 bits of the offset).

When the final item is accepted, the block pulses `done`. In the same cycle it presents a control-word update with all six exception mask bits set, which the register file is expected to write back.

A faulting instruction performs no write and raises a one-cycle fault report with a code. The waiting variant also checks for a pending unmasked exception; the no-wait variant does not.

Top module: `fpu_env_saver`

## Requirements
- R1: After reset `wr_valid`, `done`, `cw_we` and `fault_valid` are 0.
- R2: Faults are prioritised invalid-opcode (code 1) over device-not-available (code 2) over floating-point error (code 3) over alignment check (code 4). The report appears in the cycle after `start`, as `fault_valid`=1 for one cycle with `fault_code` set, and no write is issued.
- R3: `lock_pfx`=1 raises code 1. `cr0_em`=1 or `cr0_ts`=1 raises code 2 when no higher fault applies.
- R4: Code 3 is raised only when `wait_chk`=1 and `fp_pending`=1. With `wait_chk`=0 a pending exception has no effect and the image is stored.
- R5: Code 4 is raised when three conditions all hold: `align_en`=1; `dest_addr` is unaligned (low two bits nonzero for a 32-bit image, bit 0 set for a 16-bit image); and either `cpl`=3 or `v86_mode`=1. In every other case the image is stored.
- R6: A store issues exactly seven write handshakes. The first address is `dest_addr` and later addresses step by 4 with `wr_be`=4'b1111 (32-bit) or by 2 with `wr_be`=4'b0011 (16-bit). Data is right-justified in `wr_data`.
- R7: The protected 32-bit slots are, in order:
  - the control, status and tag words, each zero-extended;
  - the instruction offset;
  - {5'b0, opcode[10:0], code selector};
  - the data offset;
  - the zero-extended data selector.
- R8: The protected 16-bit items are, in order: control, status, tag, instruction offset[15:0], code selector, data offset[15:0], data selector.
- R9: The real layout is used when `prot_mode`=0 or `v86_mode`=1. Its items are, in order:
  - control, status and tag;
  - instruction linear[15:0];
  - {instruction linear[19:16], 1'b0, opcode};
  - data linear[15:0];
  - {data linear[19:16], 12'b0}.

  In the 32-bit size each item is zero-extended to 32 bits.
- R10: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold.
- R11: In the cycle after the seventh accepted handshake, `done`=1 and `cw_we`=1 for one cycle, with `cw_new` equal to the captured control word OR 16'h003F. `wr_valid` is 0 in that cycle.
- R12: The image and `cw_new` come from the values captured at `start`. Input changes and `start` pulses during a store have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction issue pulse |
| wait_chk | input | 1 | 1 = waiting variant (checks pending exception) |
| lock_pfx | input | 1 | LOCK prefix present |
| cr0_em | input | 1 | Emulation control bit |
| cr0_ts | input | 1 | Task-switched control bit |
| fp_pending | input | 1 | Pending unmasked floating-point exception |
| align_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| v86_mode | input | 1 | Virtual-8086 mode |
| prot_mode | input | 1 | Protected mode |
| op32 | input | 1 | 1 = 32-bit operand size |
| dest_addr | input | ADDR_W | Destination byte address |
| ctrl_word | input | 16 | Control word |
| stat_word | input | 16 | Status word |
| tag_word | input | 16 | Tag word |
| ip_off | input | 32 | Instruction pointer offset |
| cs_sel | input | 16 | Instruction code selector |
| last_opc | input | 11 | Last opcode |
| dp_off | input | 32 | Data pointer offset |
| ds_sel | input | 16 | Data selector |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data, right-justified |
| wr_be | output | 4 | Byte enables |
| fault_valid | output | 1 | Fault report pulse |
| fault_code | output | 3 | Fault code (1 UD, 2 NM, 3 MF, 4 AC) |
| done | output | 1 | Store complete pulse |
| cw_we | output | 1 | Control-word update strobe |
| cw_new | output | 16 | Updated control word |

## Verification
The hardest state to reach from the ports is a store in flight while the memory stalls irregularly and the environment inputs change underneath it. Stimulus runs each layout under a sparse ready pattern. Partway through one store it rewrites every environment input and pulses `start` again, then checks that the remaining items, `cw_new` and the idle cycles after `done` still reflect the captured snapshot. Fault ordering is reached by raising several fault conditions together: lock with device-not-available, device-not-available with pending, and pending with misalignment.

// File: rtl/fenv_pkg.sv
package fenv_pkg;
  localparam int NSLOT   = 7;
  localparam int IDX_W   = 3;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_MF   = 3'd3,
    FLT_AC   = 3'd4
  } fault_e;

  typedef struct packed {
    logic [15:0] cw;
    logic [15:0] sw;
    logic [15:0] tw;
    logic [31:0] ipo;
    logic [15:0] css;
    logic [10:0] opc;
    logic [31:0] dpo;
    logic [15:0] dss;
    logic        op32;
    logic        realm;
  } env_snap_t;
endpackage

// File: rtl/fenv_fault_arb.sv
module fenv_fault_arb
  import fenv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              wait_chk,
  input  logic              lock_pfx,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              fp_pending,
  input  logic              align_en,
  input  logic [1:0]        cpl,
  input  logic              v86_mode,
  input  logic              op32,
  input  logic [ADDR_W-1:0] dest_addr,
  output fault_e            fault
);
  logic misaligned;
  logic ac_hit;

  always_comb begin
    misaligned = op32 ? (dest_addr[1:0] != 2'b00) : dest_addr[0];
    ac_hit     = align_en && misaligned && ((cpl == 2'd3) || v86_mode);
    if (lock_pfx)                 fault = FLT_UD;
    else if (cr0_em || cr0_ts)    fault = FLT_NM;
    else if (wait_chk && fp_pending) fault = FLT_MF;
    else if (ac_hit)              fault = FLT_AC;
    else                          fault = FLT_NONE;
  end
endmodule

// File: rtl/fenv_image.sv
module fenv_image
  import fenv_pkg::*;
(
  input  env_snap_t        snap,
  input  logic [IDX_W-1:0] sel,
  output logic [DATA_W-1:0] data,
  output logic [BE_W-1:0]   be
);
  logic [19:0] ip_lin;
  logic [19:0] dp_lin;
  logic [15:0] real16 [NSLOT];
  logic [15:0] prot16 [NSLOT];
  logic [31:0] prot32 [NSLOT];

  always_comb begin
    ip_lin = {snap.css, 4'h0} + {4'h0, snap.ipo[15:0]};
    dp_lin = {snap.dss, 4'h0} + {4'h0, snap.dpo[15:0]};

    real16[0] = snap.cw;  prot16[0] = snap.cw;  prot32[0] = {16'h0, snap.cw};
    real16[1] = snap.sw;  prot16[1] = snap.sw;  prot32[1] = {16'h0, snap.sw};
    real16[2] = snap.tw;  prot16[2] = snap.tw;  prot32[2] = {16'h0, snap.tw};
    real16[3] = ip_lin[15:0];
    prot16[3] = snap.ipo[15:0];
    prot32[3] = snap.ipo;
    real16[4] = {ip_lin[19:16], 1'b0, snap.opc};
    prot16[4] = snap.css;
    prot32[4] = {5'h0, snap.opc, snap.css};
    real16[5] = dp_lin[15:0];
    prot16[5] = snap.dpo[15:0];
    prot32[5] = snap.dpo;
    real16[6] = {dp_lin[19:16], 12'h0};
    prot16[6] = snap.dss;
    prot32[6] = {16'h0, snap.dss};
  end

  generate
    if (NSLOT > 0) begin : g_sel
      always_comb begin
        data = '0;
        if (sel < IDX_W'(NSLOT)) begin
          if (snap.realm)     data = {16'h0, real16[sel]};
          else if (snap.op32) data = prot32[sel];
          else                data = {16'h0, prot16[sel]};
        end
        be = snap.op32 ? 4'b1111 : 4'b0011;
      end
    end
  endgenerate
endmodule

// File: rtl/fenv_seq.sv
module fenv_seq
  import fenv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MASK_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fault_e            fault,
  input  logic              op32,
  input  logic [ADDR_W-1:0] base,
  input  logic [15:0]       cw_snap,
  input  logic [DATA_W-1:0] img_data,
  input  logic [BE_W-1:0]   img_be,
  output logic [IDX_W-1:0]  sel,
  output logic              capture,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              fault_valid,
  output logic [2:0]        fault_code,
  output logic              done,
  output logic              cw_we,
  output logic [15:0]       cw_new
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);
  localparam logic [15:0]      MASK_SET = 16'((1 << MASK_BITS) - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} st_e;
  st_e              state;
  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:0] step;

  assign capture = (state == S_IDLE) && start;
  assign sel     = (state == S_LOAD) ? '0 : idx + 1'b1;
  assign step    = op32 ? ADDR_W'(4) : ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      wr_be       <= '0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      done        <= 1'b0;
      cw_we       <= 1'b0;
      cw_new      <= '0;
    end else begin
      done        <= 1'b0;
      cw_we       <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (fault != FLT_NONE) begin
              fault_valid <= 1'b1;
              fault_code  <= fault;
            end else begin
              state <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          wr_valid <= 1'b1;
          wr_addr  <= base;
          wr_data  <= img_data;
          wr_be    <= img_be;
          idx      <= '0;
          state    <= S_SEND;
        end
        S_SEND: begin
          if (wr_valid && wr_ready) begin
            if (idx == LAST_IDX) begin
              wr_valid <= 1'b0;
              done     <= 1'b1;
              cw_we    <= 1'b1;
              cw_new   <= cw_snap | MASK_SET;
              state    <= S_IDLE;
            end else begin
              idx     <= idx + 1'b1;
              wr_addr <= wr_addr + step;
              wr_data <= img_data;
              wr_be   <= img_be;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpu_env_saver.sv
module fpu_env_saver
  import fenv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MASK_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wait_chk,
  input  logic              lock_pfx,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              fp_pending,
  input  logic              align_en,
  input  logic [1:0]        cpl,
  input  logic              v86_mode,
  input  logic              prot_mode,
  input  logic              op32,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [15:0]       ctrl_word,
  input  logic [15:0]       stat_word,
  input  logic [15:0]       tag_word,
  input  logic [31:0]       ip_off,
  input  logic [15:0]       cs_sel,
  input  logic [10:0]       last_opc,
  input  logic [31:0]       dp_off,
  input  logic [15:0]       ds_sel,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  output logic              fault_valid,
  output logic [2:0]        fault_code,
  output logic              done,
  output logic              cw_we,
  output logic [15:0]       cw_new
);
  env_snap_t         snap;
  logic [ADDR_W-1:0] base;
  fault_e            fault;
  logic              capture;
  logic [IDX_W-1:0]  sel;
  logic [DATA_W-1:0] img_data;
  logic [BE_W-1:0]   img_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      base <= '0;
    end else if (capture) begin
      snap <= '{cw: ctrl_word, sw: stat_word, tw: tag_word, ipo: ip_off,
                css: cs_sel, opc: last_opc, dpo: dp_off, dss: ds_sel,
                op32: op32, realm: (!prot_mode) || v86_mode};
      base <= dest_addr;
    end
  end

  fenv_fault_arb #(.ADDR_W(ADDR_W)) u_arb (
    .wait_chk(wait_chk), .lock_pfx(lock_pfx), .cr0_em(cr0_em),
    .cr0_ts(cr0_ts), .fp_pending(fp_pending), .align_en(align_en),
    .cpl(cpl), .v86_mode(v86_mode), .op32(op32),
    .dest_addr(dest_addr), .fault(fault)
  );

  fenv_image u_img (
    .snap(snap), .sel(sel), .data(img_data), .be(img_be)
  );

  fenv_seq #(.ADDR_W(ADDR_W), .MASK_BITS(MASK_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fault(fault),
    .op32(snap.op32), .base(base), .cw_snap(snap.cw),
    .img_data(img_data), .img_be(img_be), .sel(sel), .capture(capture),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .fault_valid(fault_valid),
    .fault_code(fault_code), .done(done), .cw_we(cw_we), .cw_new(cw_new)
  );
endmodule

// File: rtl/fenv_checker.sv
module fenv_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        wr_be,
  input logic              fault_valid,
  input logic [2:0]        fault_code,
  input logic              done,
  input logic              cw_we,
  input logic [15:0]       cw_new
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be))); // R10
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> !wr_valid); // R2
  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_code >= 3'd1 && fault_code <= 3'd4)); // R2
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_be == 4'b1111 || wr_be == 4'b0011)); // R6
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_valid && wr_ready)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_valid && cw_we && cw_new[5:0] == 6'h3F)); // R11
endmodule

bind fpu_env_saver fenv_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
  .fault_valid(fault_valid), .fault_code(fault_code), .done(done),
  .cw_we(cw_we), .cw_new(cw_new)
);

// File: tb/fpu_env_saver_test.sv
`timescale 1ns/1ps
module fpu_env_saver_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, wait_chk, lock_pfx, cr0_em, cr0_ts, fp_pending, align_en;
  logic [1:0] cpl;
  logic v86_mode, prot_mode, op32;
  logic [31:0] dest_addr, ip_off, dp_off;
  logic [15:0] ctrl_word, stat_word, tag_word, cs_sel, ds_sel;
  logic [10:0] last_opc;
  logic wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic [3:0] wr_be;
  logic fault_valid, done, cw_we;
  logic [2:0] fault_code;
  logic [15:0] cw_new;

  fpu_env_saver uut (
    .clk(clk), .rst(rst), .start(start), .wait_chk(wait_chk), .lock_pfx(lock_pfx),
    .cr0_em(cr0_em), .cr0_ts(cr0_ts), .fp_pending(fp_pending), .align_en(align_en),
    .cpl(cpl), .v86_mode(v86_mode), .prot_mode(prot_mode), .op32(op32),
    .dest_addr(dest_addr), .ctrl_word(ctrl_word), .stat_word(stat_word),
    .tag_word(tag_word), .ip_off(ip_off), .cs_sel(cs_sel), .last_opc(last_opc),
    .dp_off(dp_off), .ds_sel(ds_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .fault_valid(fault_valid),
    .fault_code(fault_code), .done(done), .cw_we(cw_we), .cw_new(cw_new)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // behavioural reference for one image item
  function automatic logic [31:0] ref_item(input int k, input bit is32, input bit realm,
      input logic [15:0] cw, sw, tw, css, dss, input logic [31:0] ipo, dpo, input logic [10:0] opc);
    int ipl, dpl;
    logic [15:0] h;
    ipl = ((int'(css) * 16) + int'(ipo[15:0])) % (1 << 20);
    dpl = ((int'(dss) * 16) + int'(dpo[15:0])) % (1 << 20);
    case (k)
      0: h = cw;
      1: h = sw;
      2: h = tw;
      3: h = realm ? 16'(ipl) : ipo[15:0];
      4: h = realm ? {4'(ipl >> 16), 1'b0, opc} : css;
      5: h = realm ? 16'(dpl) : dpo[15:0];
      default: h = realm ? {4'(dpl >> 16), 12'h0} : dss;
    endcase
    if (is32 && !realm) begin
      if (k == 3) return ipo;
      if (k == 4) return {5'h0, opc, css};
      if (k == 5) return dpo;
    end
    return {16'h0, h};
  endfunction

  task automatic run_op(input string req, input bit w, lk, em, ts, pend, acen,
      input logic [1:0] cp, input bit v86, prot, o32, input logic [31:0] base,
      input logic [7:0] pat, input bit perturb);
    logic [31:0] exp_d [7];
    logic [15:0] exp_cw;
    int ef, i, cyc;
    bit misal, realm;
    @(negedge clk);
    wait_chk = w; lock_pfx = lk; cr0_em = em; cr0_ts = ts; fp_pending = pend;
    align_en = acen; cpl = cp; v86_mode = v86; prot_mode = prot; op32 = o32;
    dest_addr = base;
    ctrl_word = 16'($urandom); stat_word = 16'($urandom); tag_word = 16'($urandom);
    ip_off = $urandom; dp_off = $urandom; cs_sel = 16'($urandom);
    ds_sel = 16'($urandom); last_opc = 11'($urandom);
    realm = !prot || v86;
    misal = o32 ? (base[1:0] != 0) : base[0];
    if (lk) ef = 1;
    else if (em || ts) ef = 2;
    else if (w && pend) ef = 3;
    else if (acen && misal && (cp == 3 || v86)) ef = 4;
    else ef = 0;
    for (int k = 0; k < 7; k++)
      exp_d[k] = ref_item(k, o32, realm, ctrl_word, stat_word, tag_word, cs_sel, ds_sel,
                          ip_off, dp_off, last_opc);
    exp_cw = ctrl_word | 16'h003F;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fault_valid == (ef != 0), req, fault_valid, ef != 0);
    if (ef != 0) begin
      chk(fault_code == 3'(ef), req, fault_code, ef);
      chk(!wr_valid, req, wr_valid, 0);
      @(negedge clk);
      chk(!fault_valid && !wr_valid && !done, req, {fault_valid, wr_valid, done}, 0);
      return;
    end
    chk(!wr_valid, req, wr_valid, 0);
    @(negedge clk);
    i = 0; cyc = 0;
    while (i < 7) begin
      wr_ready = pat[cyc % 8];
      chk(wr_valid === 1'b1, req, wr_valid, 1);
      chk(wr_addr == base + (o32 ? 4 : 2) * i, {req, " R6 addr"}, wr_addr, base + (o32 ? 4 : 2) * i);
      chk(wr_be == (o32 ? 4'hF : 4'h3), {req, " R6 be"}, wr_be, o32 ? 4'hF : 4'h3);
      chk(wr_data == exp_d[i], {req, " data"}, wr_data, exp_d[i]);
      chk(!done, req, done, 0);
      if (perturb && cyc == 1) begin
        ctrl_word = ~ctrl_word; stat_word = ~stat_word; tag_word = ~tag_word;
        ip_off = ~ip_off; dp_off = ~dp_off; cs_sel = ~cs_sel; ds_sel = ~ds_sel;
        last_opc = ~last_opc; op32 = ~op32; prot_mode = ~prot_mode;
        dest_addr = dest_addr + 32'h100; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (wr_ready) i++;
      @(negedge clk);
      cyc++;
    end
    wr_ready = 1'b0;
    start = 1'b0;
    chk(done && cw_we, "R11 done strobe", {done, cw_we}, 2'b11);
    chk(cw_new == exp_cw, "R11 mask set", cw_new, exp_cw);
    chk(!wr_valid, "R11 bus idle", wr_valid, 0);
    @(negedge clk);
    chk(!done && !cw_we, "R11 single pulse", {done, cw_we}, 0);
    if (perturb) begin
      for (int q = 0; q < 3; q++) begin
        chk(!wr_valid && !fault_valid, "R12 busy start ignored", {wr_valid, fault_valid}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rst = 1'b1; start = 0; wait_chk = 0; lock_pfx = 0; cr0_em = 0; cr0_ts = 0;
    fp_pending = 0; align_en = 0; cpl = 0; v86_mode = 0; prot_mode = 1; op32 = 1;
    dest_addr = 0; ctrl_word = 0; stat_word = 0; tag_word = 0; ip_off = 0;
    cs_sel = 0; last_opc = 0; dp_off = 0; ds_sel = 0; wr_ready = 0;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !done && !cw_we && !fault_valid, "R1 reset",
        {wr_valid, done, cw_we, fault_valid}, 0);
    rst = 1'b0;
    //        req                  w lk em ts pd ac cpl v86 prt o32 base          ready      pert
    run_op("R7 prot32",            1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_1000, 8'hFF, 0);
    run_op("R8 prot16 stalls",     0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_2002, 8'b1011_0010, 0);
    run_op("R9 real32",            1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_3000, 8'b0110_1101, 0);
    run_op("R9 v86 16",            0, 0, 0, 0, 0, 0, 3, 1, 1, 0, 32'h0000_4010, 8'b1001_0011, 0);
    run_op("R10 long stalls",      1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_5000, 8'b1000_0000, 0);
    run_op("R3 lock over nm",      1, 1, 1, 0, 1, 1, 3, 0, 1, 1, 32'h0000_0003, 8'hFF, 0);
    run_op("R3 em",                0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_0000, 8'hFF, 0);
    run_op("R3 ts over mf",        1, 0, 0, 1, 1, 0, 0, 0, 1, 1, 32'h0000_0000, 8'hFF, 0);
    run_op("R4 wait pending",      1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 32'h0000_0000, 8'hFF, 0);
    run_op("R4 nowait pending",    0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 32'h0000_6000, 8'hFF, 0);
    run_op("R2 mf over ac",        1, 0, 0, 0, 1, 1, 3, 0, 1, 1, 32'h0000_0002, 8'hFF, 0);
    run_op("R5 ac cpl3",           0, 0, 0, 0, 0, 1, 3, 0, 1, 1, 32'h0000_7002, 8'hFF, 0);
    run_op("R5 no ac cpl0",        0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 32'h0000_7002, 8'hFF, 0);
    run_op("R5 ac v86 cpl0",       0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 32'h0000_7001, 8'hFF, 0);
    run_op("R5 16bit even ok",     0, 0, 0, 0, 0, 1, 3, 0, 1, 0, 32'h0000_7002, 8'hFF, 0);
    run_op("R5 ac disabled",       0, 0, 0, 0, 0, 0, 3, 0, 1, 1, 32'h0000_7001, 8'hFF, 0);
    run_op("R12 snapshot",         1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_8000, 8'b0101_0101, 1);
    run_op("R12 snapshot 16",      0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_9000, 8'b1100_1001, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule